// File: doc/BRIEF.md
# Shared-Bus SPI Master with Per-Device Edge and Rate

This block is an SPI master for a bus where several peripherals share one clock line, one master-out line and one master-in line. Each peripheral has its own active-low select. The peripherals need different clock rates and different sampling edges, for example a slow converter, a medium-speed port expander and a DAC that captures on the falling edge. A small configuration table holds a half-period divisor and an edge bit for each device. The master loads that device's entry at the start of a transfer, so one set of pins serves every device without reprogramming between transfers.

The host starts a transfer by giving a device index, a word length and the transmit word. The received word comes back with a one-cycle done strobe. After reset the bus stays in a defined quiet state for a fixed settling interval before any transfer can begin.

The control is a single state machine with seven states:

- INIT holds the bus quiet after reset for `INIT_CYC` cycles, then goes to IDLE.
- IDLE waits. A start request moves it to LEAD and latches the device's settings.
- LEAD drives the select before any clock edge, then goes to FIRST.
- FIRST and SECOND are the two halves of one bit. FIRST moves to SECOND. SECOND moves back to FIRST while bits remain, and to TRAIL after the last bit.
- TRAIL holds the select after the last edge, then goes to GAP.
- GAP releases the select and pulses done, then goes to IDLE.

Every state except IDLE lasts a counted number of cycles.

Top module: `spi_multi_master`

## Requirements
- R1: While reset is asserted and for `INIT_CYC` (default 4) cycles after the first rising clock edge following reset release, every select is high, sclk and mosi are low, busy is high and done is low. After that the block is idle with busy low.
- R2: Each device has a table entry holding a divisor (default `DEF_DIV`=2) and an edge bit (default 0). A configuration write takes effect only when it arrives while the block is idle; a write while busy is dropped. A written divisor of 0 is stored as 1.
- R3: While idle, sclk is low. During a transfer, every sclk half-phase lasts exactly the latched divisor number of clock cycles.
- R4: Each bit begins with a launch of mosi and consists of two half-phases. With edge bit 0, sclk is low then high, and miso is captured on the rising edge in the middle of the bit. With edge bit 1, sclk is high then low, and miso is captured on the falling edge in the middle of the bit.
- R5: Word length values below 8 are treated as 8 and values above 32 as 32. Transmit data goes out most-significant first, starting with tx bit (length-1). Mosi is low outside the lead and bit phases.
- R6: At most one select is ever low. The selected device's select goes low for exactly one half-period before the first sclk phase, and stays low for exactly one half-period after the last phase.
- R7: After the select is released, busy stays high for one more half-period with all selects high before a new start can be accepted.
- R8: A start request while busy is ignored, and the running transfer's waveform is unchanged.
- R9: Done is a one-cycle pulse in the first cycle after the select is released. Rx_data then holds the received bits right-aligned, first bit received as most significant, with the upper bits zero. Rx_data changes only in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_idx_i | input | IDX_W | Device entry to write |
| cfg_div_i | input | DIV_W | Half-period in clock cycles |
| cfg_edge_i | input | 1 | 0: capture on rising edge, 1: capture on falling edge |
| start_i | input | 1 | Transfer request |
| dev_i | input | IDX_W | Target device index |
| word_len_i | input | LEN_W | Bits per transfer (clamped to 8..32) |
| tx_data_i | input | MAX_W | Transmit word, right-aligned |
| busy_o | output | 1 | High while not idle |
| done_o | output | 1 | One-cycle transfer-complete strobe |
| rx_data_o | output | MAX_W | Received word, right-aligned |
| sclk_o | output | 1 | Shared serial clock |
| mosi_o | output | 1 | Shared master data out |
| miso_i | input | 1 | Shared master data in |
| ss_n_o | output | NUM_DEV | Per-device active-low selects |

## Verification
A wrong state or counter shows up at the pins within one half-period. A miscounted phase stretches or shrinks an sclk level. A wrong bit count adds or drops a clock pulse and moves the done strobe. A stale edge bit inverts the level order of each bit.

Capture on the wrong edge, or an off-by-one in the shift registers, appears as a word shifted by one bit on rx_data at the done cycle. On mosi it appears as a misplaced first bit during the lead phase.

A table write that leaks through while busy surfaces only on the next transfer to that device, as a changed phase length or edge order. The bench therefore follows such a write with a transfer to that device.

// File: rtl/spi_mm_pkg.sv
package spi_mm_pkg;

    typedef enum logic [2:0] {
        ST_INIT,
        ST_IDLE,
        ST_LEAD,
        ST_FIRST,
        ST_SECOND,
        ST_TRAIL,
        ST_GAP
    } mm_state_e;

endpackage

// File: rtl/spi_mm_cfg_table.sv
module spi_mm_cfg_table #(
    parameter int NUM_DEV = 4,
    parameter int DIV_W   = 8,
    parameter int DEF_DIV = 2,
    parameter int IDX_W   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_allow_i,
    input  logic             wr_en_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  logic [DIV_W-1:0] wr_div_i,
    input  logic             wr_edge_i,
    input  logic [IDX_W-1:0] rd_idx_i,
    output logic [DIV_W-1:0] rd_div_o,
    output logic             rd_edge_o
);

    logic [NUM_DEV-1:0][DIV_W-1:0] div_q;
    logic [NUM_DEV-1:0]            edge_q;
    logic [DIV_W-1:0]              div_clamped;

    assign div_clamped = (wr_div_i == '0) ? DIV_W'(1) : wr_div_i;

    for (genvar g = 0; g < NUM_DEV; g++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                div_q[g]  <= DIV_W'(DEF_DIV);
                edge_q[g] <= 1'b0;
            end else if (wr_allow_i && wr_en_i && (wr_idx_i == IDX_W'(g))) begin
                div_q[g]  <= div_clamped;
                edge_q[g] <= wr_edge_i;
            end
        end
    end

    assign rd_div_o  = div_q[rd_idx_i];
    assign rd_edge_o = edge_q[rd_idx_i];

    // R2
    busy_write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !wr_allow_i) |=> ($stable(div_q) && $stable(edge_q)));

    // R2
    nonzero_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_allow_i) |=> (div_q[$past(wr_idx_i)] != '0));

endmodule

// File: rtl/spi_mm_half_timer.sv
module spi_mm_half_timer #(
    parameter int CNT_W   = 8,
    parameter int RST_VAL = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] val_i,
    output logic             zero_o
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= CNT_W'(RST_VAL);
        end else if (load_i) begin
            cnt_q <= val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign zero_o = (cnt_q == '0);

    // R3
    tick_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !zero_o) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

endmodule

// File: rtl/spi_mm_shifter.sv
module spi_mm_shifter #(
    parameter int MAX_W = 32,
    parameter int LEN_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [MAX_W-1:0] tx_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             shift_out_i,
    input  logic             shift_in_i,
    input  logic             miso_i,
    output logic             mosi_bit_o,
    output logic [MAX_W-1:0] rx_o
);

    logic [MAX_W-1:0] tx_sh;
    logic [MAX_W-1:0] rx_sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sh <= '0;
            rx_sh <= '0;
        end else begin
            if (load_i) begin
                tx_sh <= tx_i << (MAX_W - int'(len_i));
                rx_sh <= '0;
            end else begin
                if (shift_out_i) begin
                    tx_sh <= {tx_sh[MAX_W-2:0], 1'b0};
                end
                if (shift_in_i) begin
                    rx_sh <= {rx_sh[MAX_W-2:0], miso_i};
                end
            end
        end
    end

    assign mosi_bit_o = tx_sh[MAX_W-1];
    assign rx_o       = rx_sh;

endmodule

// File: rtl/spi_multi_master.sv
module spi_multi_master
    import spi_mm_pkg::*;
#(
    parameter int NUM_DEV  = 4,
    parameter int DIV_W    = 8,
    parameter int DEF_DIV  = 2,
    parameter int MIN_W    = 8,
    parameter int MAX_W    = 32,
    parameter int INIT_CYC = 4,
    parameter int IDX_W    = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1,
    parameter int LEN_W    = $clog2(MAX_W) + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we_i,
    input  logic [IDX_W-1:0]   cfg_idx_i,
    input  logic [DIV_W-1:0]   cfg_div_i,
    input  logic               cfg_edge_i,
    input  logic               start_i,
    input  logic [IDX_W-1:0]   dev_i,
    input  logic [LEN_W-1:0]   word_len_i,
    input  logic [MAX_W-1:0]   tx_data_i,
    output logic               busy_o,
    output logic               done_o,
    output logic [MAX_W-1:0]   rx_data_o,
    output logic               sclk_o,
    output logic               mosi_o,
    input  logic               miso_i,
    output logic [NUM_DEV-1:0] ss_n_o
);

    mm_state_e state_q, state_nx;

    logic [IDX_W-1:0] cur_dev_q;
    logic [DIV_W-1:0] cur_div_q;
    logic             cur_edge_q;
    logic [LEN_W-1:0] bits_left_q;
    logic             done_q;
    logic [MAX_W-1:0] rx_q;

    logic [DIV_W-1:0] tbl_div;
    logic             tbl_edge;
    logic [LEN_W-1:0] len_eff;
    logic             tmr_load;
    logic [DIV_W-1:0] tmr_val;
    logic             tmr_zero;
    logic             accept;
    logic             sh_in;
    logic             sh_out;
    logic             fin;
    logic             tx_msb;
    logic [MAX_W-1:0] rx_sh;

    assign len_eff = (word_len_i < LEN_W'(MIN_W)) ? LEN_W'(MIN_W) :
                     (word_len_i > LEN_W'(MAX_W)) ? LEN_W'(MAX_W) : word_len_i;

    spi_mm_cfg_table #(
        .NUM_DEV (NUM_DEV),
        .DIV_W   (DIV_W),
        .DEF_DIV (DEF_DIV),
        .IDX_W   (IDX_W)
    ) cfg_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_allow_i (state_q == ST_IDLE),
        .wr_en_i    (cfg_we_i),
        .wr_idx_i   (cfg_idx_i),
        .wr_div_i   (cfg_div_i),
        .wr_edge_i  (cfg_edge_i),
        .rd_idx_i   (dev_i),
        .rd_div_o   (tbl_div),
        .rd_edge_o  (tbl_edge)
    );

    spi_mm_half_timer #(
        .CNT_W   (DIV_W),
        .RST_VAL (INIT_CYC)
    ) tmr_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .val_i  (tmr_val),
        .zero_o (tmr_zero)
    );

    spi_mm_shifter #(
        .MAX_W (MAX_W),
        .LEN_W (LEN_W)
    ) sh_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (accept),
        .tx_i        (tx_data_i),
        .len_i       (len_eff),
        .shift_out_i (sh_out),
        .shift_in_i  (sh_in),
        .miso_i      (miso_i),
        .mosi_bit_o  (tx_msb),
        .rx_o        (rx_sh)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_INIT;
        end else begin
            state_q <= state_nx;
        end
    end

    // Next state and phase control
    always_comb begin
        state_nx = state_q;
        tmr_load = 1'b0;
        tmr_val  = cur_div_q - DIV_W'(1);
        accept   = 1'b0;
        sh_in    = 1'b0;
        sh_out   = 1'b0;
        fin      = 1'b0;
        unique case (state_q)
            ST_INIT: begin
                if (tmr_zero) state_nx = ST_IDLE;
            end
            ST_IDLE: begin
                if (start_i) begin
                    accept   = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = tbl_div - DIV_W'(1);
                    state_nx = ST_LEAD;
                end
            end
            ST_LEAD: begin
                if (tmr_zero) begin
                    tmr_load = 1'b1;
                    state_nx = ST_FIRST;
                end
            end
            ST_FIRST: begin
                if (tmr_zero) begin
                    tmr_load = 1'b1;
                    sh_in    = 1'b1;
                    state_nx = ST_SECOND;
                end
            end
            ST_SECOND: begin
                if (tmr_zero) begin
                    tmr_load = 1'b1;
                    sh_out   = 1'b1;
                    state_nx = (bits_left_q == LEN_W'(1)) ? ST_TRAIL : ST_FIRST;
                end
            end
            ST_TRAIL: begin
                if (tmr_zero) begin
                    tmr_load = 1'b1;
                    fin      = 1'b1;
                    state_nx = ST_GAP;
                end
            end
            ST_GAP: begin
                if (tmr_zero) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // Per-transfer context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_dev_q   <= '0;
            cur_div_q   <= DIV_W'(1);
            cur_edge_q  <= 1'b0;
            bits_left_q <= '0;
            done_q      <= 1'b0;
            rx_q        <= '0;
        end else begin
            done_q <= fin;
            if (accept) begin
                cur_dev_q   <= dev_i;
                cur_div_q   <= tbl_div;
                cur_edge_q  <= tbl_edge;
                bits_left_q <= len_eff;
            end else if (sh_out) begin
                bits_left_q <= bits_left_q - LEN_W'(1);
            end
            if (fin) begin
                rx_q <= rx_sh;
            end
        end
    end

    // Pin outputs
    always_comb begin
        sclk_o = 1'b0;
        mosi_o = 1'b0;
        ss_n_o = '1;
        unique case (state_q)
            ST_LEAD: begin
                ss_n_o[cur_dev_q] = 1'b0;
                mosi_o            = tx_msb;
            end
            ST_FIRST: begin
                ss_n_o[cur_dev_q] = 1'b0;
                mosi_o            = tx_msb;
                sclk_o            = cur_edge_q;
            end
            ST_SECOND: begin
                ss_n_o[cur_dev_q] = 1'b0;
                mosi_o            = tx_msb;
                sclk_o            = ~cur_edge_q;
            end
            ST_TRAIL: begin
                ss_n_o[cur_dev_q] = 1'b0;
            end
            default: begin
                sclk_o = 1'b0;
            end
        endcase
    end

    assign busy_o    = (state_q != ST_IDLE);
    assign done_o    = done_q;
    assign rx_data_o = rx_q;

    // R6
    one_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~ss_n_o));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9
    rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_data_o != $past(rx_data_o)) |-> done_o);

    // R8
    start_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> ($stable(cur_dev_q) && $stable(cur_div_q) && $stable(cur_edge_q)));

    // R3
    half_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FIRST && !tmr_zero) |=> (state_q == ST_FIRST && $stable(sclk_o)));

    // R1
    init_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_INIT) |-> (&ss_n_o && !sclk_o && !mosi_o && busy_o));

    // R7
    gap_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GAP) |-> (&ss_n_o && busy_o));

endmodule

// File: tb/spi_multi_master_tb_top.sv
`timescale 1ns/1ps
module spi_multi_master_tb_top;

    localparam int NDEV  = 4;
    localparam int DIVW  = 8;
    localparam int INITC = 4;

    typedef struct packed {
        logic            sclk;
        logic [NDEV-1:0] ss_n;
        logic            mosi;
        logic            busy;
        logic            done;
        logic            miso;
        logic [31:0]     rx;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n;
    logic cfg_we;
    logic [1:0] cfg_idx;
    logic [DIVW-1:0] cfg_div;
    logic cfg_edge;
    logic start;
    logic [1:0] dev;
    logic [5:0] wlen;
    logic [31:0] tx;
    logic busy, done, sclk, mosi, miso;
    logic [31:0] rx_data;
    logic [NDEV-1:0] ss_n;

    exp_t q[$];
    logic [31:0] last_rx;
    int div_m[NDEV];
    bit edge_m[NDEV];
    int vectors = 0;
    int errors  = 0;
    bit ended   = 0;

    always #2 clk = ~clk;

    spi_multi_master dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we_i   (cfg_we),
        .cfg_idx_i  (cfg_idx),
        .cfg_div_i  (cfg_div),
        .cfg_edge_i (cfg_edge),
        .start_i    (start),
        .dev_i      (dev),
        .word_len_i (wlen),
        .tx_data_i  (tx),
        .busy_o     (busy),
        .done_o     (done),
        .rx_data_o  (rx_data),
        .sclk_o     (sclk),
        .mosi_o     (mosi),
        .miso_i     (miso),
        .ss_n_o     (ss_n)
    );

    task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
        end
    endtask

    function automatic exp_t mk(logic c, logic [NDEV-1:0] s, logic m, logic b,
                                logic d, logic mi, logic [31:0] r);
        exp_t e;
        e.sclk = c; e.ss_n = s; e.mosi = m; e.busy = b;
        e.done = d; e.miso = mi; e.rx = r;
        return e;
    endfunction

    task automatic check_cycle();
        exp_t e;
        if (q.size() > 0) e = q.pop_front();
        else e = mk(1'b0, '1, 1'b0, 1'b0, 1'b0, 1'b0, last_rx);
        last_rx = e.rx;
        cmp("R3/R4 sclk", {31'd0, sclk}, {31'd0, e.sclk});
        cmp("R6/R2 ss_n", {28'd0, ss_n}, {28'd0, e.ss_n});
        cmp("R5 mosi", {31'd0, mosi}, {31'd0, e.mosi});
        cmp("R1/R7/R8 busy", {31'd0, busy}, {31'd0, e.busy});
        cmp("R9 done", {31'd0, done}, {31'd0, e.done});
        cmp("R9/R4 rx_data", rx_data, e.rx);
        miso = e.miso;
    endtask

    task automatic step();
        @(negedge clk);
        check_cycle();
    endtask

    task automatic drain();
        while (q.size() > 0) step();
        step();
    endtask

    // Expected pin trace of one transfer, starting the cycle after acceptance
    task automatic push_xfer(int d_ix, int len_raw, logic [31:0] t, logic [31:0] s);
        int len;
        int d;
        bit ed;
        logic [31:0] mask;
        logic [NDEV-1:0] sel;
        len  = (len_raw < 8) ? 8 : ((len_raw > 32) ? 32 : len_raw);
        d    = div_m[d_ix];
        ed   = edge_m[d_ix];
        mask = (len == 32) ? 32'hFFFF_FFFF : ((32'd1 << len) - 32'd1);
        sel  = '1;
        sel[d_ix] = 1'b0;
        for (int i = 0; i < d; i++) q.push_back(mk(1'b0, sel, t[len-1], 1'b1, 1'b0, s[len-1], last_rx));
        for (int k = 0; k < len; k++) begin
            for (int i = 0; i < d; i++) q.push_back(mk(ed, sel, t[len-1-k], 1'b1, 1'b0, s[len-1-k], last_rx));
            for (int i = 0; i < d; i++) q.push_back(mk(!ed, sel, t[len-1-k], 1'b1, 1'b0, s[len-1-k], last_rx));
        end
        for (int i = 0; i < d; i++) q.push_back(mk(1'b0, sel, 1'b0, 1'b1, 1'b0, 1'b0, last_rx));
        for (int i = 0; i < d; i++) q.push_back(mk(1'b0, '1, 1'b0, 1'b1, (i == 0), 1'b0, s & mask));
    endtask

    task automatic run_xfer(int d_ix, int len_raw, logic [31:0] t, logic [31:0] s);
        drain();
        start = 1'b1; dev = 2'(d_ix); wlen = 6'(len_raw); tx = t;
        push_xfer(d_ix, len_raw, t, s);
        step();
        start = 1'b0;
    endtask

    // R2: table write issued while idle
    task automatic write_cfg(int d_ix, int dv, bit ed);
        drain();
        cfg_we = 1'b1; cfg_idx = 2'(d_ix); cfg_div = DIVW'(dv); cfg_edge = ed;
        div_m[d_ix]  = (dv == 0) ? 1 : dv;
        edge_m[d_ix] = ed;
        step();
        cfg_we = 1'b0;
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_idx = '0; cfg_div = '0; cfg_edge = 1'b0;
        start = 1'b0; dev = '0; wlen = 6'd8; tx = '0; miso = 1'b0; last_rx = '0;
        for (int i = 0; i < NDEV; i++) begin div_m[i] = 2; edge_m[i] = 0; end
        repeat (3) @(negedge clk);
        // R1: quiet bus during reset
        cmp("R1 ss_n reset", {28'd0, ss_n}, 32'hF);
        cmp("R1 sclk reset", {31'd0, sclk}, 32'd0);
        cmp("R1 mosi reset", {31'd0, mosi}, 32'd0);
        cmp("R1 busy reset", {31'd0, busy}, 32'd1);
        cmp("R1 done reset", {31'd0, done}, 32'd0);
        rst_n = 1'b1;
        for (int i = 0; i < INITC; i++) q.push_back(mk(1'b0, '1, 1'b0, 1'b1, 1'b0, 1'b0, 32'd0));

        // R4 rising capture with default table entry (R2 defaults)
        run_xfer(0, 8, 32'h0000_00A5, 32'h0000_003C);
        // R4 falling capture, R3 divisor 3
        write_cfg(1, 3, 1);
        run_xfer(1, 16, 32'h0000_C35A, 32'h0000_9F01);
        // R5 full 32-bit word, divisor 1
        write_cfg(2, 1, 0);
        run_xfer(2, 32, 32'hDEAD_BEEF, 32'h1234_5679);
        // R2 divisor 0 stored as 1; R5 short length clamped to 8
        write_cfg(3, 0, 1);
        run_xfer(3, 5, 32'hFFFF_FF96, 32'h0000_0081);
        // R5 long length clamped to 32
        run_xfer(2, 40, 32'h8000_0001, 32'hF0F0_F00F);

        // R8 start while busy and R2 write while busy, both ignored
        run_xfer(1, 12, 32'h0000_0A5C, 32'h0000_0F3A);
        repeat (10) step();
        start = 1'b1; dev = 2'd0; wlen = 6'd8; tx = 32'hFF;
        cfg_we = 1'b1; cfg_idx = 2'd1; cfg_div = 8'd7; cfg_edge = 1'b0;
        step();
        start = 1'b0; cfg_we = 1'b0;
        run_xfer(1, 8, 32'h0000_0033, 32'h0000_00CC);

        // R4 same device switched to falling capture between transfers
        write_cfg(0, 2, 1);
        run_xfer(0, 8, 32'h0000_0069, 32'h0000_0096);
        // R6 back-to-back transfers to different devices
        run_xfer(3, 9, 32'h0000_0155, 32'h0000_01AA);
        run_xfer(0, 10, 32'h0000_02F0, 32'h0000_030F);
        drain();
        repeat (4) step();
        finish_run();
    end

endmodule